// File: doc/BRIEF.md
# DMA interrupt and status aggregator

This block sits beside a scatter-gather DMA engine and collects its event pulses (error, end of packet, descriptor done, chain done) into a sticky status word. It also shows the engine's live busy level in that word. From these events it forms one level-sensitive interrupt line. Each source has its own enable, and a global enable gates all of them.

A second interrupt path counts completed descriptors. It fires when the count reaches an 8-bit threshold held in the control word. Software reads and writes two 32-bit words through a simple CSR port: status at word address 0 and control at word address 1. Writing 1 to the top bit of control acknowledges the interrupt and wipes the sticky state.

Top module: `dma_irq_status`

## Requirements
- R1: Status word (address 0) bits are error = bit 0, end of packet = bit 1, descriptor done = bit 2, chain done = bit 3. Each is set by its event pulse, stays set until cleared, and becomes visible on the cycle after the pulse. Bits 31..5 read 0.
- R2: Status bit 4 shows the `eng_busy` input combinationally, with no delay.
- R3: Control bits 0..3 enable the error, end of packet, descriptor done and chain done sources. Bit 4 is a global enable. An event whose source enable and the global enable are both set raises `irq` on the next cycle. With the global enable clear, no event raises `irq`.
- R4: Once set, `irq` stays high until it is cleared, even if every enable is then turned off.
- R5: A write to address 1 with bit 31 set clears `irq`, status bits 3..0 and the descriptor counter. An event in that same cycle is still recorded, and it may raise `irq` again on the next cycle.
- R6: Control bit 31 always reads 0. The other bits written in the same write are stored as in any other control write.
- R7: Control bits 0..4, 7 and 15..8 are writable and read back as written. All other control bits read 0. Addresses 2 and 3 read 0. A control write takes effect from the next cycle.
- R8: Control bit 7 enables the count interrupt, and bits 15..8 hold the threshold T. Each descriptor-done pulse increments the counter. When the counter reaches T (T nonzero), it wraps to 0 and, if bits 7 and 4 are both set, `irq` rises on the next cycle. T = 0 never fires.
- R9: After reset, `irq` is 0 and the status (apart from busy) and control words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_err | input | 1 | Engine error pulse |
| ev_eop | input | 1 | End-of-packet pulse |
| ev_desc_done | input | 1 | Descriptor completed pulse |
| ev_chain_done | input | 1 | Chain completed pulse |
| eng_busy | input | 1 | Engine busy level |
| csr_wr | input | 1 | Write strobe |
| csr_addr | input | ADDR_W | Word address |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
Errors in the sticky status bits, the stored control word or the interrupt flop are visible at the ports on the first cycle after the faulty update: as a wrong `csr_rdata` on the next read, or as a wrong `irq` level. A corrupted descriptor counter stays hidden until the threshold is next reached. At that point `irq` rises one descriptor early or late, so the bench runs small thresholds many times to bring that moment close. Clears that coincide with events and threshold-zero runs are driven on purpose, because those are where a priority mistake would show.

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
  parameter int ADDR_W  = 2,
  parameter int THR_W   = 8,
  parameter int THR_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_err,
  input  logic              ev_eop,
  input  logic              ev_desc_done,
  input  logic              ev_chain_done,
  input  logic              eng_busy,
  input  logic              csr_wr,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(1);
  localparam logic [31:0] THR_MASK  = ((32'd1 << THR_W) - 32'd1) << THR_LSB;
  localparam logic [31:0] CTRL_MASK = 32'h0000_009F | THR_MASK;

  logic [3:0]       sts_q;
  logic [31:0]      ctrl_q;
  logic [THR_W-1:0] cnt_q;
  logic             irq_q;

  wire [3:0]       evv     = {ev_chain_done, ev_desc_done, ev_eop, ev_err};
  wire             wr_ctrl = csr_wr && (csr_addr == A_CTRL);
  wire             clr     = wr_ctrl && csr_wdata[31];
  wire [THR_W-1:0] thr     = ctrl_q[THR_LSB +: THR_W];
  wire [THR_W-1:0] cnt_b   = clr ? '0 : cnt_q;
  wire [THR_W-1:0] cnt_inc = cnt_b + THR_W'(1);
  wire             hit     = ev_desc_done && (thr != '0) && (cnt_inc == thr);
  wire             fire    = ctrl_q[4] && ((|(evv & ctrl_q[3:0])) || (ctrl_q[7] && hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q  <= '0;
      ctrl_q <= '0;
      cnt_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      sts_q <= (clr ? 4'b0 : sts_q) | evv;
      if (wr_ctrl) ctrl_q <= csr_wdata & CTRL_MASK;
      cnt_q <= hit ? '0 : (ev_desc_done ? cnt_inc : cnt_b);
      irq_q <= (irq_q && !clr) || fire;
    end
  end

  always_comb begin
    case (csr_addr)
      A_STS:   csr_rdata = {27'b0, eng_busy, sts_q};
      A_CTRL:  csr_rdata = ctrl_q;
      default: csr_rdata = '0;
    endcase
  end

  assign irq = irq_q;
endmodule

module dma_irq_status_chk #(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_err,
  input logic              ev_eop,
  input logic              ev_desc_done,
  input logic              ev_chain_done,
  input logic              eng_busy,
  input logic              csr_wr,
  input logic [ADDR_W-1:0] csr_addr,
  input logic [31:0]       csr_wdata,
  input logic [31:0]       csr_rdata,
  input logic              irq,
  input logic [31:0]       ctrl_q,
  input logic [3:0]        sts_q
);
  wire clr_w  = csr_wr && (csr_addr == ADDR_W'(1)) && csr_wdata[31];
  wire any_ev = ev_err || ev_eop || ev_desc_done || ev_chain_done;

  p_busy_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == ADDR_W'(0)) |-> (csr_rdata[4] == eng_busy));

  p_sts_rsvd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == ADDR_W'(0)) |-> (csr_rdata[31:5] == 27'b0));

  p_gie_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ctrl_q[4]));

  p_irq_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_w) |=> irq);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w && !any_ev) |=> (!irq && sts_q == 4'b0));

  p_bit31_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == ADDR_W'(1)) |-> !csr_rdata[31]);
endmodule

bind dma_irq_status dma_irq_status_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_err(ev_err), .ev_eop(ev_eop),
  .ev_desc_done(ev_desc_done), .ev_chain_done(ev_chain_done),
  .eng_busy(eng_busy), .csr_wr(csr_wr), .csr_addr(csr_addr),
  .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq(irq),
  .ctrl_q(ctrl_q), .sts_q(sts_q)
);

// File: tb/tb_dma_irq_status.sv
`timescale 1ns/1ps
module tb_dma_irq_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_err = 0, ev_eop = 0, ev_desc_done = 0, ev_chain_done = 0;
  logic        eng_busy = 0, csr_wr = 0;
  logic [1:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  logic [3:0]  m_sts = '0;
  logic [31:0] m_ctrl = '0;
  logic [7:0]  m_cnt = '0;
  logic        m_irq = 1'b0;

  always #2 clk = ~clk;

  dma_irq_status dut (
    .clk(clk), .rst_n(rst_n), .ev_err(ev_err), .ev_eop(ev_eop),
    .ev_desc_done(ev_desc_done), .ev_chain_done(ev_chain_done),
    .eng_busy(eng_busy), .csr_wr(csr_wr), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [1:0] a, input logic b);
    case (a)
      2'd0:    return {27'b0, b, m_sts};
      2'd1:    return m_ctrl;
      default: return 32'b0;
    endcase
  endfunction

  task automatic model_step();
    logic       clr, hit;
    logic [3:0] evv;
    logic [7:0] base, inc, thr;
    logic       fire;
    evv  = {ev_chain_done, ev_desc_done, ev_eop, ev_err};
    clr  = csr_wr && csr_addr == 2'd1 && csr_wdata[31];
    thr  = m_ctrl[15:8];
    base = clr ? 8'd0 : m_cnt;
    inc  = base + 8'd1;
    hit  = ev_desc_done && thr != 0 && inc == thr;
    fire = m_ctrl[4] && ((|(evv & m_ctrl[3:0])) || (m_ctrl[7] && hit));
    m_sts = (clr ? 4'b0 : m_sts) | evv;
    if (csr_wr && csr_addr == 2'd1) m_ctrl = csr_wdata & 32'h0000_FF9F;
    m_cnt = hit ? 8'd0 : (ev_desc_done ? inc : base);
    m_irq = (m_irq && !clr) || fire;
  endtask

  task automatic cyc(input logic wr, input logic [1:0] a, input logic [31:0] wd,
                     input logic [3:0] ev, input logic b);
    csr_wr = wr; csr_addr = a; csr_wdata = wd; eng_busy = b;
    {ev_chain_done, ev_desc_done, ev_eop, ev_err} = ev;
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R3 irq", {31'b0, irq}, {31'b0, m_irq});
    chk(a == 2'd0 ? "R1 status read" : "R7 ctrl read", csr_rdata, exp_rd(a, b));
  endtask

  task automatic idle(); cyc(0, 2'd0, 32'h0, 4'h0, 1'b0); endtask

  task automatic rd(input logic [1:0] a);
    csr_wr = 0; csr_addr = a; #0.1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #50;
    @(negedge clk);
    rd(2'd0); chk("R9 status after reset", csr_rdata, 32'h0);
    rd(2'd1); chk("R9 ctrl after reset", csr_rdata, 32'h0);
    chk("R9 irq after reset", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    idle();

    cyc(1, 2'd1, 32'hFFFF_FFFF, 4'h0, 1'b0);
    rd(2'd1); chk("R6 bit31 reads zero", {31'b0, csr_rdata[31]}, 32'h0);
    chk("R7 writable mask", csr_rdata, 32'h0000_FF9F);
    rd(2'd2); chk("R7 unmapped reads zero", csr_rdata, 32'h0);
    cyc(1, 2'd1, 32'h8000_0000, 4'h0, 1'b0);

    cyc(1, 2'd0, 32'h0, 4'h0, 1'b1);
    rd(2'd0); eng_busy = 1'b1; #0.1; chk("R2 busy live high", {31'b0, csr_rdata[4]}, 32'h1);
    eng_busy = 1'b0; #0.1; chk("R2 busy live low", {31'b0, csr_rdata[4]}, 32'h0);

    cyc(1, 2'd1, 32'h0000_000F, 4'h0, 1'b0);
    cyc(0, 2'd0, 32'h0, 4'hF, 1'b0);
    chk("R3 no irq with global enable off", {31'b0, irq}, 32'h0);
    rd(2'd0); chk("R1 sticky bits set", csr_rdata, 32'h0000_000F);
    idle(); rd(2'd0); chk("R1 sticky bits held", csr_rdata, 32'h0000_000F);
    cyc(1, 2'd1, 32'h8000_0000, 4'h0, 1'b0);
    rd(2'd0); chk("R5 clear wipes status", csr_rdata, 32'h0);

    cyc(1, 2'd1, 32'h0000_0011, 4'h0, 1'b0);
    cyc(0, 2'd0, 32'h0, 4'h1, 1'b0);
    chk("R3 error raises irq", {31'b0, irq}, 32'h1);
    cyc(1, 2'd1, 32'h0000_0000, 4'h0, 1'b0);
    repeat (3) idle();
    chk("R4 irq held after disable", {31'b0, irq}, 32'h1);
    cyc(1, 2'd1, 32'h8000_0012, 4'h0, 1'b0);
    chk("R5 clear drops irq", {31'b0, irq}, 32'h0);
    rd(2'd1); chk("R6 other bits stored with clear", csr_rdata, 32'h0000_0012);
    cyc(0, 2'd0, 32'h0, 4'h2, 1'b0);
    cyc(1, 2'd1, 32'h8000_0012, 4'h2, 1'b0);
    chk("R5 event in clear cycle re-raises irq", {31'b0, irq}, 32'h1);
    rd(2'd0); chk("R5 event in clear cycle recorded", csr_rdata, 32'h0000_0002);
    cyc(1, 2'd1, 32'h8000_0000, 4'h0, 1'b0);

    cyc(1, 2'd1, 32'h0000_0390, 4'h0, 1'b0);
    cyc(0, 2'd0, 32'h0, 4'h4, 1'b0);
    cyc(0, 2'd0, 32'h0, 4'h4, 1'b0);
    chk("R8 below threshold", {31'b0, irq}, 32'h0);
    cyc(0, 2'd0, 32'h0, 4'h4, 1'b0);
    chk("R8 threshold reached", {31'b0, irq}, 32'h1);
    cyc(1, 2'd1, 32'h8000_0390, 4'h0, 1'b0);
    cyc(0, 2'd0, 32'h0, 4'h4, 1'b0);
    cyc(0, 2'd0, 32'h0, 4'h4, 1'b0);
    chk("R8 counter restarted", {31'b0, irq}, 32'h0);
    cyc(0, 2'd0, 32'h0, 4'h4, 1'b0);
    chk("R8 fires again after wrap", {31'b0, irq}, 32'h1);
    cyc(1, 2'd1, 32'h8000_0090, 4'h0, 1'b0);
    repeat (300) cyc(0, 2'd0, 32'h0, 4'h4, 1'b0);
    chk("R8 threshold zero never fires", {31'b0, irq}, 32'h0);

    for (int i = 0; i < 5000; i++) begin
      logic [31:0] wd;
      logic [3:0]  ev;
      int sel;
      sel = $urandom % 20;
      ev  = {($urandom % 8) == 0, ($urandom % 3) == 0, ($urandom % 8) == 0, ($urandom % 10) == 0};
      wd  = ($urandom & 32'h8000_009F) | (($urandom % 6) << 8) | 32'h10;
      if (($urandom % 8) == 0) wd[31] = 1'b0;
      if (sel == 0)      cyc(1, 2'd1, wd, ev, $urandom % 2);
      else if (sel == 1) cyc(1, 2'd1, 32'h8000_0000 | m_ctrl, ev, $urandom % 2);
      else               cyc($urandom % 2, 2'($urandom), $urandom & 32'h7FFF_FFFF, ev, $urandom % 2);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule